// File: doc/BRIEF.md
# Double-Buffered Endpoint Ready Tracker

This block holds the packet-ready state of one bulk or interrupt USB endpoint whose receive and transmit FIFOs each have two buffer layers, A and B. Every layer has its own ready flag. Two pointers, one for the serial engine and one for the local processor, walk each pair of layers in turn. Neither side ever picks a layer itself.

The local processor sees one 8-bit status word. Bit 0 reads 1 while any receive layer holds an unread packet. Writing 1 to bit 0 releases the oldest such layer. Bit 1 reads 1 while any transmit layer holds prepared data. Writing 1 to bit 1 marks the layer being filled as ready. On the USB side, the block takes end-of-packet strobes that carry an error-free flag or an acknowledged flag. It returns two NAK decisions and the layer index each side must use.

The endpoint refuses OUT data only when both receive layers are occupied. It refuses IN tokens only when no transmit layer is ready. A received packet with an error, or an IN transfer that times out, changes nothing. The same layer is therefore refilled or sent again.

Top module: `pp_ep_status`

## Requirements
- R1: After a hardware reset (rst_n low), and on the clock after a synchronous bus_reset pulse, every status bit reads 0. All four layer pointers also read 0, which means layer A (1 means layer B).
- R2: While ep_en is 0, reg_rdata reads 0 and out_nak and in_nak are both 1. Processor writes and USB strobes leave no trace once ep_en returns to 1.
- R3: A strobe on rx_done with rx_ok=1 marks the receive layer at rx_usb_layer as ready and toggles rx_usb_layer. Bit 0 of reg_rdata reads 1 while either receive layer is ready.
- R4: A strobe on rx_done with rx_ok=0 changes no flag and no pointer.
- R5: While both receive layers are ready, out_nak is 1. A good-packet strobe in that state changes nothing.
- R6: A write with bit 0 set clears the ready receive layer at rx_mcu_layer and toggles rx_mcu_layer. out_nak drops to 0 after the first such clear. Bit 0 stays 1 while the other layer is still ready.
- R7: A write with bit 1 set marks the transmit layer at tx_mcu_layer as ready and toggles tx_mcu_layer. When both transmit layers are already ready, the write has no effect.
- R8: in_nak is 1 exactly when no transmit layer is ready. Bit 1 of reg_rdata reads 1 when at least one is ready.
- R9: A strobe on tx_done with tx_acked=1 clears the ready transmit layer at tx_usb_layer and toggles tx_usb_layer. With tx_acked=0, or with no layer ready, the strobe has no effect.
- R10: Writing 0 to bits 0 and 1 changes nothing. Writing 1 to bit 0 while no receive layer is ready changes nothing.
- R11: Bits 7 down to 2 of reg_rdata always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_reset | input | 1 | Synchronous USB bus reset, active high |
| ep_en | input | 1 | Endpoint is configured for bulk or interrupt transfer |
| reg_wr | input | 1 | Processor write strobe to the status word |
| reg_wdata | input | 8 | Write data: bit 0 releases a receive layer, bit 1 arms a transmit layer |
| reg_rdata | output | 8 | Status word: bit 0 receive ready, bit 1 transmit ready |
| rx_done | input | 1 | End of an OUT data packet |
| rx_ok | input | 1 | The packet ending with rx_done was error-free |
| tx_done | input | 1 | End of an IN transfer |
| tx_acked | input | 1 | The host acknowledged the IN transfer ending with tx_done |
| out_nak | output | 1 | Answer the next OUT data with NAK |
| in_nak | output | 1 | Answer the next IN token with NAK |
| rx_usb_layer | output | 1 | Receive layer the serial engine writes next |
| rx_mcu_layer | output | 1 | Receive layer the processor reads next |
| tx_usb_layer | output | 1 | Transmit layer the serial engine sends next |
| tx_mcu_layer | output | 1 | Transmit layer the processor fills next |

## Verification
The assertions check, on every cycle, the relations that hold at any moment:
- reserved bits stay zero;
- NAK is asserted whenever both receive layers are full, or whenever no transmit layer is ready;
- the receive bit falls only after a processor clear, a bus reset or a disable;
- the transmit bit falls only after an acknowledge, a bus reset or a disable;
- the status word is zero after a bus reset or while the endpoint is disabled.

Some behaviour shows only in the bench's scenarios. These are the order in which the pointers step through layers A and B, the lock and unlock of the receive pair, and the ignored strobes and writes (errored packets, timeouts, clears with nothing ready, arms with both layers ready). The bench also confirms that a disabled period leaves no state behind.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;

    localparam int unsigned LAYERS = 2;

    // State of one pair of buffer layers: ready flags plus the
    // producer-side and consumer-side layer pointers (0 = A, 1 = B).
    typedef struct packed {
        logic [LAYERS-1:0] rdy;
        logic              fill_ptr;
        logic              drain_ptr;
    } pp_pair_t;

endpackage

// File: rtl/pp_layer_pair.sv
module pp_layer_pair
    import pp_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fill,
    input  logic              drain,
    output logic [LAYERS-1:0] rdy,
    output logic              fill_ptr,
    output logic              drain_ptr,
    output logic              any_rdy,
    output logic              all_rdy
);

    pp_pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Producer fills only an empty layer, consumer drains only a full
        // one, so both can never act on the same layer in one cycle.
        if (fill && !st_q.rdy[st_q.fill_ptr]) begin
            st_d.rdy[st_q.fill_ptr] = 1'b1;
            st_d.fill_ptr           = ~st_q.fill_ptr;
        end
        if (drain && st_q.rdy[st_q.drain_ptr]) begin
            st_d.rdy[st_q.drain_ptr] = 1'b0;
            st_d.drain_ptr           = ~st_q.drain_ptr;
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy       = st_q.rdy;
    assign fill_ptr  = st_q.fill_ptr;
    assign drain_ptr = st_q.drain_ptr;
    assign any_rdy   = |st_q.rdy;
    assign all_rdy   = &st_q.rdy;

endmodule

// File: rtl/pp_stat_regif.sv
module pp_stat_regif #(
    parameter int unsigned STAT_W = 8,
    parameter int unsigned RX_BIT = 0,
    parameter int unsigned TX_BIT = 1
) (
    input  logic              en,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              rx_any,
    input  logic              tx_any,
    output logic              rx_release,
    output logic              tx_arm,
    output logic [STAT_W-1:0] rdata
);

    logic unused_wbits;

    always_comb begin
        rdata         = '0;
        rdata[RX_BIT] = en & rx_any;
        rdata[TX_BIT] = en & tx_any;
    end

    assign rx_release   = en & wr & wdata[RX_BIT];
    assign tx_arm       = en & wr & wdata[TX_BIT];
    assign unused_wbits = ^wdata;

endmodule

// File: rtl/pp_ep_status.sv
module pp_ep_status
    import pp_ep_pkg::*;
#(
    parameter int unsigned STAT_W = 8,
    parameter int unsigned RX_BIT = 0,
    parameter int unsigned TX_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              ep_en,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              tx_done,
    input  logic              tx_acked,
    output logic              out_nak,
    output logic              in_nak,
    output logic              rx_usb_layer,
    output logic              rx_mcu_layer,
    output logic              tx_usb_layer,
    output logic              tx_mcu_layer
);

    logic              clr;
    logic              rx_release, tx_arm;
    logic              rx_any, rx_all, tx_any, tx_all;
    logic [LAYERS-1:0] rx_rdy, tx_rdy;

    assign clr = bus_reset | ~ep_en;

    pp_stat_regif #(
        .STAT_W (STAT_W),
        .RX_BIT (RX_BIT),
        .TX_BIT (TX_BIT)
    ) i_regif (
        .en         (ep_en),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .rx_any     (rx_any),
        .tx_any     (tx_any),
        .rx_release (rx_release),
        .tx_arm     (tx_arm),
        .rdata      (reg_rdata)
    );

    // Receive: the serial engine produces, the processor consumes.
    pp_layer_pair i_rx_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .fill      (ep_en & rx_done & rx_ok),
        .drain     (rx_release),
        .rdy       (rx_rdy),
        .fill_ptr  (rx_usb_layer),
        .drain_ptr (rx_mcu_layer),
        .any_rdy   (rx_any),
        .all_rdy   (rx_all)
    );

    // Transmit: the processor produces, the serial engine consumes.
    pp_layer_pair i_tx_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .fill      (tx_arm),
        .drain     (ep_en & tx_done & tx_acked),
        .rdy       (tx_rdy),
        .fill_ptr  (tx_mcu_layer),
        .drain_ptr (tx_usb_layer),
        .any_rdy   (tx_any),
        .all_rdy   (tx_all)
    );

    logic unused_tx_all;
    assign unused_tx_all = tx_all;

    assign out_nak = ~ep_en | rx_all;
    assign in_nak  = ~ep_en | ~tx_any;

endmodule

// File: rtl/pp_ep_status_chk.sv
module pp_ep_status_chk #(
    parameter int unsigned STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_reset,
    input logic              ep_en,
    input logic              reg_wr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] reg_rdata,
    input logic              tx_done,
    input logic              tx_acked,
    input logic              out_nak,
    input logic              in_nak,
    input logic [1:0]        rx_rdy,
    input logic [1:0]        tx_rdy
);

    p_busreset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (reg_rdata == '0));

    p_disabled_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_en |-> (reg_rdata == '0) && out_nak && in_nak);

    p_locked_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy == 2'b11) |-> out_nak);

    p_rx_falls_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[0]) |->
            $past(reg_wr && reg_wdata[0]) || $past(bus_reset) || $past(!ep_en));

    p_in_nak_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy == 2'b00) |-> in_nak);

    p_tx_bit_vs_nak_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ep_en |-> (in_nak == !reg_rdata[1]));

    p_tx_falls_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[1]) |->
            $past(tx_done && tx_acked) || $past(bus_reset) || $past(!ep_en));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[STAT_W-1:2] == '0);

endmodule

bind pp_ep_status pp_ep_status_chk #(.STAT_W(STAT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .ep_en     (ep_en),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_done   (tx_done),
    .tx_acked  (tx_acked),
    .out_nak   (out_nak),
    .in_nak    (in_nak),
    .rx_rdy    (rx_rdy),
    .tx_rdy    (tx_rdy)
);

// File: tb/test_pp_ep_status.sv
`timescale 1ns/1ps
module test_pp_ep_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       ep_en = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_done = 1'b0, rx_ok = 1'b0, tx_done = 1'b0, tx_acked = 1'b0;
    logic       out_nak, in_nak;
    logic       rx_usb_layer, rx_mcu_layer, tx_usb_layer, tx_mcu_layer;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pp_ep_status i_pp_ep_status (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .ep_en(ep_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_done(rx_done), .rx_ok(rx_ok), .tx_done(tx_done), .tx_acked(tx_acked),
        .out_nak(out_nak), .in_nak(in_nak),
        .rx_usb_layer(rx_usb_layer), .rx_mcu_layer(rx_mcu_layer),
        .tx_usb_layer(tx_usb_layer), .tx_mcu_layer(tx_mcu_layer)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; results are sampled at the next one.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic mcu_write(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic usb_rx(input logic ok);
        rx_done = 1'b1; rx_ok = ok; tick(); rx_done = 1'b0; rx_ok = 1'b0;
    endtask

    task automatic usb_tx(input logic ack);
        tx_done = 1'b1; tx_acked = ack; tick(); tx_done = 1'b0; tx_acked = 1'b0;
    endtask

    // {rx_usb, rx_mcu, tx_usb, tx_mcu}
    function automatic logic [3:0] ptrs();
        return {rx_usb_layer, rx_mcu_layer, tx_usb_layer, tx_mcu_layer};
    endfunction

    task automatic t_reset();
        chk("R1 status after reset", reg_rdata, 8'h00);
        chk("R1 pointers after reset", ptrs(), 4'b0000);
        chk("R1 out_nak after reset", out_nak, 1'b0);
        chk("R8 in_nak with no tx layer", in_nak, 1'b1);
    endtask

    task automatic t_receive();
        usb_rx(1'b1);
        chk("R3 rx bit after first packet", reg_rdata[0], 1'b1);
        chk("R3 rx pointers after first packet", {rx_usb_layer, rx_mcu_layer}, 2'b10);
        chk("R3 no lock with one layer", out_nak, 1'b0);
        usb_rx(1'b0);
        chk("R4 errored packet keeps usb pointer", rx_usb_layer, 1'b1);
        chk("R4 errored packet keeps lock state", out_nak, 1'b0);
        usb_rx(1'b1);
        chk("R5 lock with both layers", out_nak, 1'b1);
        chk("R3 usb pointer back to A", rx_usb_layer, 1'b0);
        usb_rx(1'b1);
        chk("R5 packet while locked ignored", {out_nak, rx_usb_layer}, 2'b10);
        mcu_write(8'h00);
        chk("R10 zero write keeps rx state", {reg_rdata[0], out_nak, rx_mcu_layer}, 3'b110);
        mcu_write(8'h01);
        chk("R6 first clear unlocks", out_nak, 1'b0);
        chk("R6 rx bit held by other layer", reg_rdata[0], 1'b1);
        chk("R6 mcu pointer to B", rx_mcu_layer, 1'b1);
        mcu_write(8'h01);
        chk("R6 second clear empties", {reg_rdata[0], rx_mcu_layer}, 2'b00);
        mcu_write(8'h01);
        chk("R10 clear with nothing ready", {reg_rdata[0], rx_mcu_layer}, 2'b00);
        usb_rx(1'b1);
        chk("R3 reception resumes", {reg_rdata[0], rx_usb_layer}, 2'b11);
        mcu_write(8'h01);
    endtask

    task automatic t_transmit();
        mcu_write(8'h02);
        chk("R7 arm sets tx bit", reg_rdata[1], 1'b1);
        chk("R8 in_nak drops", in_nak, 1'b0);
        chk("R7 mcu tx pointer to B", tx_mcu_layer, 1'b1);
        usb_tx(1'b0);
        chk("R9 timeout keeps tx state", {reg_rdata[1], tx_usb_layer}, 2'b10);
        mcu_write(8'h02);
        chk("R7 second arm", tx_mcu_layer, 1'b0);
        mcu_write(8'h02);
        chk("R7 arm with both ready ignored", tx_mcu_layer, 1'b0);
        usb_tx(1'b1);
        chk("R9 first ack", {reg_rdata[1], tx_usb_layer, in_nak}, 3'b110);
        usb_tx(1'b1);
        chk("R9 second ack empties", {reg_rdata[1], tx_usb_layer, in_nak}, 3'b001);
        usb_tx(1'b1);
        chk("R9 ack with nothing ready", {reg_rdata[1], tx_usb_layer}, 2'b00);
        chk("R7 arm while full left one layer only", tx_mcu_layer, 1'b0);
    endtask

    task automatic t_reserved();
        mcu_write(8'hFF);
        chk("R11 reserved bits read 0", reg_rdata[7:2], 6'h00);
        chk("R11 live bits after full write", reg_rdata[1:0], 2'b10);
    endtask

    task automatic t_bus_reset();
        usb_rx(1'b1);
        mcu_write(8'h02);
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        chk("R1 status after bus reset", reg_rdata, 8'h00);
        chk("R1 pointers after bus reset", ptrs(), 4'b0000);
    endtask

    task automatic t_disable();
        ep_en = 1'b0; tick();
        chk("R2 disabled reads 0", reg_rdata, 8'h00);
        chk("R2 disabled nak both", {out_nak, in_nak}, 2'b11);
        mcu_write(8'h02);
        usb_rx(1'b1);
        chk("R2 disabled ignores stimulus", reg_rdata, 8'h00);
        ep_en = 1'b1; tick();
        chk("R2 no trace after enable", {reg_rdata, ptrs()}, 12'h000);
        chk("R2 nak after enable", {out_nak, in_nak}, 2'b01);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_receive();
        t_transmit();
        t_reserved();
        t_bus_reset();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule